// File: doc/BRIEF.md
# Addressed Peripheral Interface Unit

This unit connects one slow peripheral to a simple processor bus. It answers only to bus cycles that carry its own configured device address. A bus cycle carries one of four command classes. A control command clears the error and overrun conditions. A test command returns a status word. A read command fetches one byte from the peripheral. A write command sends one byte to it.

Data moves through a single buffer register. The processor starts a transfer and leaves the bus at once. It learns the outcome, and picks up read data, by issuing test commands.

On the peripheral side the unit runs a four-phase request/acknowledge dialogue that carries 8 data bits and one even-parity bit. Received parity is checked. A mismatch, or an external fault input, puts the unit into error status.

Top module: `apu_top`

## Requirements
- R1: After synchronous reset the unit has no peripheral request, no bus response, an all-zero buffer, a clear overrun flag and ready status.
- R2: A bus cycle (bus_sel high) whose address differs from DEV_ADDR has no effect: there is no response and no peripheral transfer.
- R3: bus_cmd encodes control=00, test=01, read=10 and write=11. An addressed test produces bus_rvalid for one cycle after the command cycle. The word on bus_rdata is {buffer[7:0] in bits 15:8, zeros in bits 7:3, overrun in bit 2, status in bits 1:0}, taken from the state just before the command edge.
- R4: The status code is error=11, busy=10 and ready=01. Error outranks busy, and busy outranks ready. Busy lasts from the accepted read or write until the cycle after the peripheral withdraws its acknowledge.
- R5: An accepted read raises per_req with per_dir=0. The byte on per_rdata is loaded into the buffer on the cycle per_ack is seen high. A later test returns it.
- R6: An accepted write loads bus_wdata into the buffer. It then raises per_req with per_dir=1, drives the buffer on per_wdata and drives per_wpar as its even parity (the XOR of the 8 bits).
- R7: On a read, when per_rdata and per_rpar together hold an odd number of ones, the byte is still loaded and the status becomes error.
- R8: While dev_fault is high the error status is forced. Error stays set until a control command arrives with no fault and no parity error in that cycle.
- R9: A read or write accepted while a transfer is in progress is ignored. The buffer and the transfer in progress are unchanged, and a sticky overrun flag is set. A control command clears the overrun flag.
- R10: per_req stays high until per_ack is seen high. It then drops, and no new transfer starts until per_ack has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus cycle strobe, one command per cycle |
| bus_addr | input | ADDR_W | Bus address |
| bus_cmd | input | 2 | Command class |
| bus_wdata | input | DATA_W | Write data |
| bus_rvalid | output | 1 | Test response valid |
| bus_rdata | output | DATA_W+8 | Test response word |
| per_req | output | 1 | Transfer request to peripheral |
| per_dir | output | 1 | 1 = write to peripheral, 0 = read |
| per_wdata | output | DATA_W | Byte sent to peripheral |
| per_wpar | output | 1 | Even parity of per_wdata |
| per_ack | input | 1 | Peripheral acknowledge |
| per_rdata | input | DATA_W | Byte from peripheral |
| per_rpar | input | 1 | Parity bit from peripheral |
| dev_fault | input | 1 | External device fault |

## Verification
Reads are exercised with several peripheral latencies and data values, and writes with bytes of both parity values. This separates wrong capture timing from wrong parity generation.

Bus cycles to a foreign address, and read/write commands issued while a transfer is in progress, show whether decode and busy gating leave the buffer and the handshake untouched. A read with corrupted parity and a held fault line, each followed by control commands, show the error priority and the stickiness of the error and overrun flags. A behavioural model compares the handshake and response outputs on every clock.

// File: rtl/apu_pkg.sv
// Shared encodings for the addressed peripheral interface unit.
package apu_pkg;
    typedef enum logic [1:0] {
        CMD_CTRL  = 2'b00,
        CMD_TEST  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } apu_cmd_e;

    typedef enum logic [1:0] {
        ST_READY = 2'b01,
        ST_BUSY  = 2'b10,
        ST_ERROR = 2'b11
    } apu_stat_e;

    typedef enum logic [1:0] {
        LK_IDLE = 2'b00,
        LK_REQ  = 2'b01,
        LK_REL  = 2'b10
    } link_state_e;

    localparam int NUM_CMDS = 4;
endpackage

// File: rtl/apu_decode.sv
// Address match and command decode.
// Purpose: turn one bus cycle into at most one command strobe.
// Assumes: one command per bus_sel cycle; purely combinational.
module apu_decode
    import apu_pkg::*;
#(
    parameter int                 ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]  DEV_ADDR = 8'h4C
) (
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_cmd,
    output logic              hit_ctrl,
    output logic              hit_test,
    output logic              hit_read,
    output logic              hit_write
);
    logic                addr_match;
    logic [NUM_CMDS-1:0] hit_vec;

    // Address recognition for the single configured device
    assign addr_match = bus_sel && (bus_addr == DEV_ADDR);

    // One strobe per command class
    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_cmd
        assign hit_vec[i] = addr_match && (bus_cmd == 2'(i));
    end

    assign hit_ctrl  = hit_vec[CMD_CTRL];
    assign hit_test  = hit_vec[CMD_TEST];
    assign hit_read  = hit_vec[CMD_READ];
    assign hit_write = hit_vec[CMD_WRITE];
endmodule

// File: rtl/apu_link.sv
// Peripheral link: four-phase request/acknowledge engine plus buffer register.
// Purpose: move one byte to or from the peripheral per accepted command.
// Assumes: the peripheral holds per_ack until per_req drops, and read data is
// valid while per_ack is high.
module apu_link
    import apu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              per_ack,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_rpar,
    output logic              per_req,
    output logic              per_dir,
    output logic [DATA_W-1:0] per_wdata,
    output logic              per_wpar,
    output logic              busy,
    output logic              ignored,
    output logic              par_err,
    output logic [DATA_W-1:0] buf_q
);
    link_state_e state_q;
    logic        dir_q;

    // Handshake sequencing, direction latch and buffer loading
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
            dir_q   <= 1'b0;
            buf_q   <= '0;
        end else begin
            case (state_q)
                LK_IDLE: begin
                    if (start_rd) begin
                        state_q <= LK_REQ;
                        dir_q   <= 1'b0;
                    end else if (start_wr) begin
                        state_q <= LK_REQ;
                        dir_q   <= 1'b1;
                        buf_q   <= wdata;
                    end
                end
                LK_REQ: begin
                    if (per_ack) begin
                        if (!dir_q) buf_q <= per_rdata;
                        state_q <= LK_REL;
                    end
                end
                LK_REL: begin
                    if (!per_ack) state_q <= LK_IDLE;
                end
                default: state_q <= LK_IDLE;
            endcase
        end
    end

    // Port drives and side-band flags
    assign per_req   = (state_q == LK_REQ);
    assign per_dir   = dir_q;
    assign per_wdata = buf_q;
    assign per_wpar  = ^buf_q;
    assign busy      = (state_q != LK_IDLE);
    assign ignored   = busy && (start_rd || start_wr);
    assign par_err   = per_req && per_ack && !dir_q && (^{per_rdata, per_rpar});

    // R10: request withdrawn once acknowledge is seen
    p_req_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && per_ack |=> !per_req);

    // R10: request and direction held while waiting for acknowledge
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        per_req && !per_ack |=> per_req && $stable(per_dir));

    // R9: a command refused while busy leaves the buffer alone
    p_busy_keeps_buf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ignored && !(per_req && per_ack) |=> $stable(buf_q));

    // R10: no new request before the acknowledge has been released
    p_no_req_while_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !per_req && per_ack |=> !per_req);
endmodule

// File: rtl/apu_status.sv
// Status flags and test response register.
// Purpose: hold the sticky error and overrun flags and form the status word.
// Assumes: at most one command strobe per cycle.
module apu_status
    import apu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_ctrl,
    input  logic              hit_test,
    input  logic              dev_fault,
    input  logic              par_err,
    input  logic              busy,
    input  logic              ignored,
    input  logic [DATA_W-1:0] buf_q,
    output logic              rsp_valid,
    output logic [DATA_W+7:0] rsp_data
);
    logic      err_q;
    logic      ovr_q;
    apu_stat_e stat;

    // Status code with error over busy over ready
    always_comb begin
        if (err_q)     stat = ST_ERROR;
        else if (busy) stat = ST_BUSY;
        else           stat = ST_READY;
    end

    // Sticky error and overrun flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            err_q <= dev_fault || par_err || (err_q && !hit_ctrl);
            ovr_q <= ignored || (ovr_q && !hit_ctrl);
        end
    end

    // Test response word, registered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= hit_test;
            if (hit_test) rsp_data <= {buf_q, 5'b0, ovr_q, stat};
        end
    end

    // R8: fault forces error
    p_fault_sets_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_fault |=> err_q);

    // R7: parity mismatch sets error
    p_parity_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> err_q);

    // R9: control clears overrun
    p_ctrl_clears_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |=> !ovr_q);

    // R3: one response per addressed test
    p_test_response_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_test |=> rsp_valid);

    // R2: no response without an addressed test
    p_no_stray_response_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_test |=> !rsp_valid);
endmodule

// File: rtl/apu_top.sv
// Addressed peripheral interface unit, top level.
// Purpose: connect decode, peripheral link and status logic.
// Assumes: synchronous active-low reset, a single clock domain, and a
// peripheral that follows the four-phase request/acknowledge protocol.
module apu_top
    import apu_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_cmd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W+7:0] bus_rdata,
    output logic              per_req,
    output logic              per_dir,
    output logic [DATA_W-1:0] per_wdata,
    output logic              per_wpar,
    input  logic              per_ack,
    input  logic [DATA_W-1:0] per_rdata,
    input  logic              per_rpar,
    input  logic              dev_fault
);
    logic              hit_ctrl, hit_test, hit_read, hit_write;
    logic              busy, ignored, par_err;
    logic [DATA_W-1:0] buf_q;

    apu_decode #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_decode (
        .bus_sel   (bus_sel),
        .bus_addr  (bus_addr),
        .bus_cmd   (bus_cmd),
        .hit_ctrl  (hit_ctrl),
        .hit_test  (hit_test),
        .hit_read  (hit_read),
        .hit_write (hit_write)
    );

    apu_link #(.DATA_W(DATA_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rd  (hit_read),
        .start_wr  (hit_write),
        .wdata     (bus_wdata),
        .per_ack   (per_ack),
        .per_rdata (per_rdata),
        .per_rpar  (per_rpar),
        .per_req   (per_req),
        .per_dir   (per_dir),
        .per_wdata (per_wdata),
        .per_wpar  (per_wpar),
        .busy      (busy),
        .ignored   (ignored),
        .par_err   (par_err),
        .buf_q     (buf_q)
    );

    apu_status #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_ctrl  (hit_ctrl),
        .hit_test  (hit_test),
        .dev_fault (dev_fault),
        .par_err   (par_err),
        .busy      (busy),
        .ignored   (ignored),
        .buf_q     (buf_q),
        .rsp_valid (bus_rvalid),
        .rsp_data  (bus_rdata)
    );
endmodule

// File: tb/apu_top_tb_top.sv
`timescale 1ns/1ps
module apu_top_tb_top;
    localparam logic [7:0] MY_ADDR = 8'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_cmd = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rvalid;
    logic [15:0] bus_rdata;
    logic        per_req, per_dir, per_wpar;
    logic [7:0]  per_wdata;
    logic        per_ack = 1'b0;
    logic [7:0]  per_rdata = '0;
    logic        per_rpar = 1'b0;
    logic        dev_fault = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // responder controls
    int         rsp_lat = 2;
    logic [7:0] rsp_data = '0;
    bit         rsp_bad = 0;
    int         rsp_cnt = 0;
    int         req_rises = 0;
    bit         prev_req = 0;

    always #2 clk = ~clk;

    apu_top #(.ADDR_W(8), .DATA_W(8), .DEV_ADDR(MY_ADDR)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .per_req(per_req), .per_dir(per_dir),
        .per_wdata(per_wdata), .per_wpar(per_wpar), .per_ack(per_ack),
        .per_rdata(per_rdata), .per_rpar(per_rpar), .dev_fault(dev_fault)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st = 0;        // 0 idle, 1 requesting, 2 waiting release
    bit          m_dir = 0;
    logic [7:0]  m_buf = '0;
    bit          m_err = 0, m_ovr = 0, m_rv = 0;
    logic [15:0] m_rd = '0;

    function automatic logic [1:0] m_stat();
        if (m_err) return 2'b11;
        if (m_st != 0) return 2'b10;
        return 2'b01;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_dir = 0; m_buf = '0; m_err = 0; m_ovr = 0;
            m_rv = 0; m_rd = '0;
        end else begin
            bit hit, pe, ign, ctl;
            hit = bus_sel && (bus_addr == MY_ADDR);
            ctl = hit && bus_cmd == 2'd0;
            ign = hit && bus_cmd[1] && (m_st != 0);
            pe  = (m_st == 1) && per_ack && !m_dir &&
                  ((^per_rdata) != per_rpar);
            m_rv = hit && bus_cmd == 2'd1;
            if (m_rv) m_rd = {m_buf, 5'b0, m_ovr, m_stat()};
            m_err = dev_fault || pe || (m_err && !ctl);
            m_ovr = ign || (m_ovr && !ctl);
            if (m_st == 0) begin
                if (hit && bus_cmd == 2'd2) begin m_st = 1; m_dir = 0; end
                else if (hit && bus_cmd == 2'd3) begin
                    m_st = 1; m_dir = 1; m_buf = bus_wdata;
                end
            end else if (m_st == 1) begin
                if (per_ack) begin
                    if (!m_dir) m_buf = per_rdata;
                    m_st = 2;
                end
            end else if (!per_ack) m_st = 0;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 model per_req", 16'(per_req), 16'(m_st == 1));
            if (m_st != 0) chk("R10 model per_dir", 16'(per_dir), 16'(m_dir));
            chk("R6 model per_wdata", 16'(per_wdata), 16'(m_buf));
            chk("R6 model per_wpar", 16'(per_wpar), 16'(^m_buf));
            chk("R3 model bus_rvalid", 16'(bus_rvalid), 16'(m_rv));
            chk("R3 model bus_rdata", bus_rdata, m_rd);
        end
    end

    // peripheral responder
    always @(negedge clk) begin
        if (!rst_n) begin
            per_ack = 0; rsp_cnt = 0;
        end else if (per_req && !per_ack) begin
            rsp_cnt++;
            if (rsp_cnt >= rsp_lat) begin
                per_ack = 1;
                per_rdata = rsp_data;
                per_rpar = (^rsp_data) ^ rsp_bad;
            end
        end else if (!per_req && per_ack) begin
            per_ack = 0; rsp_cnt = 0;
        end
        if (per_req && !prev_req) req_rises++;
        prev_req = per_req;
    end

    task automatic bus_op(input logic [7:0] a, input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_addr = a; bus_cmd = c; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic test_expect(input string tag, input logic [15:0] exp);
        bus_op(MY_ADDR, 2'd1, 8'h00);
        chk({tag, " rvalid"}, 16'(bus_rvalid), 16'h1);
        chk({tag, " status word"}, bus_rdata, exp);
    endtask

    task automatic wait_idle();
        while (per_req || per_ack) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset per_req", 16'(per_req), 16'h0);
        chk("R1 reset rvalid", 16'(bus_rvalid), 16'h0);
        test_expect("R1 reset", 16'h0001);

        // R2 foreign address
        bus_op(8'h4D, 2'd1, 8'h00);
        chk("R2 foreign test no response", 16'(bus_rvalid), 16'h0);
        bus_op(8'hCC, 2'd2, 8'h00);
        chk("R2 foreign read no request", 16'(per_req), 16'h0);
        @(negedge clk);
        chk("R2 foreign read still no request", 16'(per_req), 16'h0);

        // R5 read, latency 3, busy visible (R4)
        rsp_lat = 3; rsp_data = 8'hA5; rsp_bad = 0;
        bus_op(MY_ADDR, 2'd2, 8'h00);
        chk("R5 read request", 16'(per_req), 16'h1);
        chk("R5 read dir", 16'(per_dir), 16'h0);
        test_expect("R4 busy during read", 16'h0002);
        wait_idle();
        test_expect("R5 read data in buffer", 16'hA501);

        // R6 write, parity 0
        rsp_lat = 1;
        bus_op(MY_ADDR, 2'd3, 8'h3C);
        chk("R6 write dir", 16'(per_dir), 16'h1);
        chk("R6 write data", 16'(per_wdata), 16'h003C);
        chk("R6 write parity", 16'(per_wpar), 16'h0);
        wait_idle();
        test_expect("R6 after write", 16'h3C01);

        // R9 commands while busy ignored, overrun sticky
        rsp_lat = 6; rsp_data = 8'h5A;
        begin
            int r0;
            r0 = req_rises;
            bus_op(MY_ADDR, 2'd2, 8'h00);
            bus_op(MY_ADDR, 2'd3, 8'hFF);
            bus_op(MY_ADDR, 2'd2, 8'h00);
            chk("R9 write ignored keeps buffer", 16'(per_wdata), 16'h003C);
            wait_idle();
            repeat (3) @(negedge clk);
            chk("R9 single transfer", 16'(req_rises - r0), 16'h1);
        end
        test_expect("R9 overrun set", 16'h5A05);
        bus_op(MY_ADDR, 2'd0, 8'h00);
        test_expect("R9 control clears overrun", 16'h5A01);

        // R7 bad parity read
        rsp_lat = 2; rsp_data = 8'h81; rsp_bad = 1;
        bus_op(MY_ADDR, 2'd2, 8'h00);
        wait_idle();
        rsp_bad = 0;
        test_expect("R7 parity error", 16'h8103);
        bus_op(MY_ADDR, 2'd0, 8'h00);
        test_expect("R7 control clears error", 16'h8101);

        // R8 fault
        dev_fault = 1;
        @(negedge clk);
        test_expect("R8 fault forces error", 16'h8103);
        bus_op(MY_ADDR, 2'd0, 8'h00);
        test_expect("R8 control during fault", 16'h8103);
        dev_fault = 0;
        @(negedge clk);
        test_expect("R8 error sticky after fault", 16'h8103);
        bus_op(MY_ADDR, 2'd0, 8'h00);
        test_expect("R8 cleared", 16'h8101);

        // R6 write with odd byte, parity 1; R10 hold under long latency
        rsp_lat = 5;
        bus_op(MY_ADDR, 2'd3, 8'h07);
        chk("R6 odd parity", 16'(per_wpar), 16'h1);
        repeat (2) @(negedge clk);
        chk("R10 request held", 16'(per_req), 16'h1);
        wait_idle();
        test_expect("R6 after odd write", 16'h0701);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule